// File: doc/BRIEF.md
# Power-Management I/O Window Decoder

This block keeps the configuration-space state that places a 128-byte power-management I/O range in I/O space and turns it on or off. It decodes every I/O cycle against that range. Configuration accesses use dword granularity: a 6-bit dword index, four byte enables and 32-bit write data. Read data comes back one cycle after the read request, together with a valid flag. The I/O side takes a strobe and a 16-bit address. It returns a hit flag and the 7-bit offset inside the window, and these feed a downstream register file that is not part of this block.

Neither interface has back-pressure. Every configuration request is accepted in the cycle it is presented, and every read answers exactly one cycle later. The decode is combinational against the stored registers, so a write that completes at one clock edge steers the decode from that edge on. Reset returns every register to its default, whenever reset is applied.

Top module: `pmw_window_decoder`

## Requirements
- R1: The base register is dword index 0x12 (byte offset 0x48), byte lanes 0 and 1. Its bits 15:7 are writable and hold the window base. Its bits 6:1 always read 0, and bits 31:16 of that dword read 0.
- R2: Bit 0 of the base register always reads 1, whatever value is written to it.
- R3: With decoding enabled, an I/O strobe hits when io_addr[15:7] equals the stored base bits 15:7. On a hit, win_off equals io_addr[6:0], so the window spans exactly 128 bytes.
- R4: The enable bit is bit 7 of byte offset 0x41, which is cfg_wdata/cfg_rdata bit 15 of dword index 0x10. While it is 0, no I/O access hits, even with a base programmed.
- R5: Reset, applied at any time, returns the base register to 0x0001 and both general bytes at offsets 0x40 and 0x41 to 0x00.
- R6: A configuration write that changes the base or the enable affects the decode in the first cycle after the write's clock edge.
- R7: Writes honour the byte enables. A write with only lane 0 set to dword 0x12 changes only base bit 7 and leaves bits 15:8 unchanged.
- R8: When there is no hit (strobe low, outside the window, or decoding disabled), win_hit is 0 and win_off is 0.
- R9: cfg_rvalid rises one cycle after cfg_rd. Reads of any dword other than 0x10 and 0x12 return 0.
- R10: The general bytes at offsets 0x40 and 0x41 (dword 0x10, bits 15:0) read back as written. Bits 31:16 of dword 0x10 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores defaults |
| cfg_wr | input | 1 | Configuration write request |
| cfg_rd | input | 1 | Configuration read request |
| cfg_idx | input | 6 | Dword index (byte offset / 4) |
| cfg_be | input | 4 | Byte-lane enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd |
| io_strobe | input | 1 | I/O cycle present |
| io_addr | input | 16 | I/O address |
| win_hit | output | 1 | Access falls in the enabled window |
| win_off | output | 7 | Offset in the window, 0 when no hit |

## Verification
The bench walks addresses just below, just above and at both ends of the 128-byte window. A decoder with an off-by-one mask would hit at 0x..7F below the window, or miss the last byte. It writes all ones to the base and reads back the low bits, to catch a design that stores bits 6:1 or drops the hard-wired bit 0. A lane-0-only write must move the window by 128 bytes without touching the upper byte, and a design that ignored byte enables would move it elsewhere. Clearing the enable and then asserting reset in mid-run must silence the decode, even for address 0 against a reset base of 0, which is a trap for a design that decodes without the enable.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
  localparam int unsigned CFG_IDX_W = 6;
  localparam int unsigned CFG_DW    = 32;
  localparam int unsigned CFG_LANES = CFG_DW / 8;

  localparam logic [CFG_IDX_W-1:0] IDX_GENCFG = 6'h10;
  localparam logic [CFG_IDX_W-1:0] IDX_PMBASE = 6'h12;

  // enable sits in byte offset 0x41 bit 7 -> dword bit 15
  localparam int unsigned EN_BIT = 15;

  function automatic logic [CFG_DW-1:0] lane_merge(
    input logic [CFG_DW-1:0]    cur,
    input logic [CFG_DW-1:0]    upd,
    input logic [CFG_LANES-1:0] be
  );
    logic [CFG_DW-1:0] res;
    for (int i = 0; i < CFG_LANES; i++)
      res[i*8 +: 8] = be[i] ? upd[i*8 +: 8] : cur[i*8 +: 8];
    return res;
  endfunction
endpackage

// File: rtl/pmw_cfg_regs.sv
module pmw_cfg_regs
  import pmw_pkg::*;
#(
  parameter int unsigned IO_AW   = 16,
  parameter int unsigned WIN_LG2 = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic                  cfg_rd,
  input  logic [CFG_IDX_W-1:0]  cfg_idx,
  input  logic [CFG_LANES-1:0]  cfg_be,
  input  logic [CFG_DW-1:0]     cfg_wdata,
  output logic [CFG_DW-1:0]     cfg_rdata,
  output logic                  cfg_rvalid,
  output logic [IO_AW-WIN_LG2-1:0] base_o,
  output logic                  en_o
);
  localparam int unsigned BASE_W = IO_AW - WIN_LG2;
  localparam int unsigned GEN_W  = 16;

  logic [GEN_W-1:0]  gen_q;
  logic [BASE_W-1:0] base_q;
  logic [CFG_DW-1:0] gen_img, base_img, gen_new, base_new, rd_mux;

  always_comb begin
    gen_img  = '0;
    gen_img[GEN_W-1:0] = gen_q;
    base_img = '0;
    base_img[IO_AW-1:WIN_LG2] = base_q;
    base_img[0] = 1'b1;
    gen_new  = lane_merge(gen_img, cfg_wdata, cfg_be);
    base_new = lane_merge(base_img, cfg_wdata, cfg_be);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= '0;
      base_q <= '0;
    end else if (cfg_wr) begin
      if (cfg_idx == IDX_GENCFG) gen_q  <= gen_new[GEN_W-1:0];
      if (cfg_idx == IDX_PMBASE) base_q <= base_new[IO_AW-1:WIN_LG2];
    end
  end

  always_comb begin
    case (cfg_idx)
      IDX_GENCFG: rd_mux = gen_img;
      IDX_PMBASE: rd_mux = base_img;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rdata  <= '0;
      cfg_rvalid <= 1'b0;
    end else begin
      cfg_rvalid <= cfg_rd;
      cfg_rdata  <= cfg_rd ? rd_mux : '0;
    end
  end

  assign base_o = base_q;
  assign en_o   = gen_q[EN_BIT];

  // R1 / R2: low bits of the base read as 0...01
  p_base_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_idx == IDX_PMBASE) |=>
      (cfg_rdata[WIN_LG2-1:0] == {{(WIN_LG2-1){1'b0}}, 1'b1}));
  p_bit0_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_idx == IDX_PMBASE) |=> cfg_rdata[0]);
  // R9: unimplemented offsets read zero, answer one cycle later
  p_unimpl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_idx != IDX_PMBASE && cfg_idx != IDX_GENCFG) |=>
      (cfg_rvalid && cfg_rdata == '0));
endmodule

// File: rtl/pmw_addr_match.sv
module pmw_addr_match #(
  parameter int unsigned IO_AW   = 16,
  parameter int unsigned WIN_LG2 = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     io_strobe,
  input  logic [IO_AW-1:0]         io_addr,
  input  logic [IO_AW-WIN_LG2-1:0] base_i,
  input  logic                     en_i,
  output logic                     hit_o,
  output logic [WIN_LG2-1:0]       off_o
);
  logic page_eq;

  assign page_eq = (io_addr[IO_AW-1:WIN_LG2] == base_i);
  assign hit_o   = io_strobe & en_i & page_eq;
  assign off_o   = hit_o ? io_addr[WIN_LG2-1:0] : '0;

  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !hit_o);
  p_idle_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (off_o == '0));
  p_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !io_strobe |-> !hit_o);
endmodule

// File: rtl/pmw_window_decoder.sv
module pmw_window_decoder
  import pmw_pkg::*;
#(
  parameter int unsigned IO_AW   = 16,
  parameter int unsigned WIN_LG2 = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_rd,
  input  logic [5:0]           cfg_idx,
  input  logic [3:0]           cfg_be,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  output logic                 cfg_rvalid,
  input  logic                 io_strobe,
  input  logic [IO_AW-1:0]     io_addr,
  output logic                 win_hit,
  output logic [WIN_LG2-1:0]   win_off
);
  logic [IO_AW-WIN_LG2-1:0] base;
  logic                     en;

  pmw_cfg_regs #(.IO_AW(IO_AW), .WIN_LG2(WIN_LG2)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_idx(cfg_idx), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .base_o(base), .en_o(en)
  );

  pmw_addr_match #(.IO_AW(IO_AW), .WIN_LG2(WIN_LG2)) u_match (
    .clk(clk), .rst_n(rst_n), .io_strobe(io_strobe), .io_addr(io_addr),
    .base_i(base), .en_i(en), .hit_o(win_hit), .off_o(win_off)
  );

  // R6: clearing the enable silences the decode from the next cycle
  p_follow_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_idx == IDX_GENCFG && cfg_be[1] && !cfg_wdata[EN_BIT]) |=> !win_hit);
  // R3: a hit carries the low address bits as offset
  p_hit_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> (win_off == io_addr[WIN_LG2-1:0]));
endmodule

// File: tb/tb_pmw_window_decoder.sv
module tb_pmw_window_decoder;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic        io_strobe = 1'b0;
  logic [15:0] io_addr = '0;
  logic        win_hit;
  logic [6:0]  win_off;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmw_window_decoder dut (.*);

  // {strobe, addr[15:0], hit, off[6:0]} with base 0x1A80 enabled (R3, R8)
  localparam logic [24:0] VEC [8] = '{
    {1'b1, 16'h1A80, 1'b1, 7'h00},
    {1'b1, 16'h1AFF, 1'b1, 7'h7F},
    {1'b1, 16'h1A7F, 1'b0, 7'h00},
    {1'b1, 16'h1B00, 1'b0, 7'h00},
    {1'b0, 16'h1A90, 1'b0, 7'h00},
    {1'b1, 16'h9A80, 1'b0, 7'h00},
    {1'b1, 16'h1AC5, 1'b1, 7'h45},
    {1'b1, 16'h0000, 1'b0, 7'h00}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_read(input logic [5:0] idx, output logic [31:0] d, output logic v);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_idx = idx;
    @(negedge clk);
    d = cfg_rdata; v = cfg_rvalid;
    cfg_rd = 1'b0;
  endtask

  task automatic probe(input logic s, input logic [15:0] a, input logic eh, input logic [6:0] eo, input string tag);
    @(negedge clk);
    io_strobe = s; io_addr = a;
    #1;
    chk(win_hit === eh, {tag, " hit"}, 32'(win_hit), 32'(eh));
    chk(win_off === eo, {tag, " off"}, 32'(win_off), 32'(eo));
    io_strobe = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5 reset state, R9 read latency
    cfg_read(6'h12, d, v);
    chk(v === 1'b1, "R9 rvalid", 32'(v), 1);
    chk(d === 32'h0000_0001, "R5 base default", d, 32'h1);
    cfg_read(6'h10, d, v);
    chk(d === 32'h0, "R5 gencfg default", d, 0);
    probe(1'b1, 16'h0000, 1'b0, 7'h0, "R4 disabled at reset");

    // R1 R2: write all ones, low bits masked
    cfg_write(6'h12, 4'hF, 32'hFFFF_FFFE);
    cfg_read(6'h12, d, v);
    chk(d === 32'h0000_FF81, "R1 R2 base all ones", d, 32'hFF81);
    cfg_write(6'h12, 4'h3, 32'h0000_1A80);
    cfg_read(6'h12, d, v);
    chk(d === 32'h0000_1A81, "R1 base program", d, 32'h1A81);

    // R4 base set but not enabled
    probe(1'b1, 16'h1A80, 1'b0, 7'h0, "R4 base without enable");

    // R10 general bytes, enable
    cfg_write(6'h10, 4'hF, 32'hFFFF_80A5);
    cfg_read(6'h10, d, v);
    chk(d === 32'h0000_80A5, "R10 gencfg readback", d, 32'h80A5);

    // R3 R8 vector table
    foreach (VEC[i]) begin
      probe(VEC[i][24], VEC[i][23:8], VEC[i][7], VEC[i][6:0], "R3 R8 vector");
    end

    // R7 lane 0 only: base moves to 0x1A00; R6 decode follows at once
    cfg_write(6'h12, 4'h1, 32'hFFFF_FF00);
    cfg_read(6'h12, d, v);
    chk(d === 32'h0000_1A01, "R7 lane0 write", d, 32'h1A01);
    probe(1'b1, 16'h1A05, 1'b1, 7'h05, "R6 R7 new window");
    probe(1'b1, 16'h1A85, 1'b0, 7'h00, "R6 old window");

    // R9 unimplemented offsets
    cfg_read(6'h05, d, v);
    chk(d === 32'h0, "R9 unimpl 0x14", d, 0);
    cfg_read(6'h11, d, v);
    chk(d === 32'h0, "R9 unimpl 0x44", d, 0);

    // R4 R6 disable via lane 1 only, R10 lane 0 untouched
    cfg_write(6'h10, 4'h2, 32'h0000_0000);
    probe(1'b1, 16'h1A05, 1'b0, 7'h00, "R4 R6 disabled");
    cfg_read(6'h10, d, v);
    chk(d === 32'h0000_00A5, "R10 R7 lane1 clear", d, 32'hA5);

    // R5 mid-run reset after re-enable
    cfg_write(6'h10, 4'h2, 32'h0000_8000);
    probe(1'b1, 16'h1A05, 1'b1, 7'h05, "R6 re-enabled");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    probe(1'b1, 16'h1A05, 1'b0, 7'h00, "R5 after reset");
    probe(1'b1, 16'h0010, 1'b0, 7'h00, "R5 base zero not enabled");
    cfg_read(6'h12, d, v);
    chk(d === 32'h0000_0001, "R5 base after reset", d, 32'h1);
    cfg_read(6'h10, d, v);
    chk(d === 32'h0, "R5 gencfg after reset", d, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule